// File: doc/BRIEF.md
# Cipher Block FIFO and DMA Front End

This block sits in front of a block-cipher engine and moves data in and out of it. Words written through a 32-bit data-in port go into an 8-entry input FIFO. Once four words have arrived, they are packed into one 128-bit block and passed to the engine over a valid/ready handshake. The engine returns a 128-bit result, which is split into four words and placed in an 8-entry output FIFO. Software or a DMA controller reads those words through the data-out port.

Two DMA request pairs, one for input and one for output, pace the transfers. Each pair has a single-word line and a four-word burst line. A pending output request holds back the input requests, so results drain before more input is accepted. Status flags report input space, output data, engine activity and a sticky overflow error. A FIFO interrupt is formed from raw flags, each masked by its own enable.

A unit enable starts block processing. A flush control empties both FIFOs, but only while the unit enable is low.

Top module: `cfd_front`

## Requirements
- R1: After reset: inNotFull=1, outNotEmpty=0, busy=0, ovfErr=0, rdData=0, and engInValid=0.
- R2: inNotFull is high exactly when the input FIFO holds fewer than 8 words. A write to a full FIFO leaves its contents unchanged and sets ovfErr. ovfErr stays set until an accepted flush.
- R3: outNotEmpty is high exactly when the output FIFO holds a word. rdData shows the oldest word. When the FIFO is empty, rdData is 0, and a read has no effect on the pointers.
- R4: engInValid is high only when all of the following hold: unitEn=1, the input FIFO holds at least 4 words, the output FIFO has at least 4 free slots, and busy=0. The earliest written word is in engInData[31:0], and later words occupy the higher 32-bit lanes in order.
- R5: busy rises on the clock edge that completes an input handshake. It falls when the engine's result is accepted, and engOutReady equals busy. Result lane engOutData[31:0] is read out of the output FIFO first.
- R6: With inDmaEn=1 and no output request pending, inDmaBurst is high when at least 4 input slots are free. inDmaSingle is high when 1 to 3 slots are free. Both are low when the FIFO is full.
- R7: With outDmaEn=1, outDmaBurst is high when at least 4 words are in the output FIFO. outDmaSingle is high when 1 to 3 words are present.
- R8: While either output request line is high, both input request lines are low.
- R9: A flushReq with unitEn=0 empties both FIFOs and clears ovfErr on the next edge. A flushReq with unitEn=1 has no effect.
- R10: irqRaw is {outNotEmpty, inNotFull}. irqMasked is irqRaw ANDed with {outIrqEn, inIrqEn}. irq is the OR of the irqMasked bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| unitEn | input | 1 | Unit enable; allows block handoff |
| flushReq | input | 1 | Flush both FIFOs (only when unitEn=0) |
| inDmaEn | input | 1 | Input DMA request enable |
| outDmaEn | input | 1 | Output DMA request enable |
| inIrqEn | input | 1 | Interrupt enable for input-not-full |
| outIrqEn | input | 1 | Interrupt enable for output-not-empty |
| wrEn | input | 1 | Data-in write strobe |
| wrData | input | 32 | Data-in word |
| rdEn | input | 1 | Data-out read strobe |
| rdData | output | 32 | Oldest output word, or 0 when empty |
| inNotFull | output | 1 | Input FIFO can take a word |
| outNotEmpty | output | 1 | Output FIFO has a word |
| busy | output | 1 | Block in flight in the engine |
| ovfErr | output | 1 | Sticky write-while-full error |
| irqRaw | output | 2 | {outNotEmpty, inNotFull} |
| irqMasked | output | 2 | irqRaw gated by enables |
| irq | output | 1 | FIFO interrupt |
| inDmaSingle | output | 1 | Input single-word request |
| inDmaBurst | output | 1 | Input 4-word burst request |
| outDmaSingle | output | 1 | Output single-word request |
| outDmaBurst | output | 1 | Output 4-word burst request |
| engInValid | output | 1 | Block offered to engine |
| engInReady | input | 1 | Engine accepts block |
| engInData | output | 128 | Block to engine, earliest word in low lane |
| engOutValid | input | 1 | Engine result valid |
| engOutReady | output | 1 | Result accepted (equals busy) |
| engOutData | input | 128 | Result block, low lane read first |

## Verification
A wrong FIFO count shows up at once on the request lines: inDmaBurst and inDmaSingle change on the same cycle as the written word, and an off-by-one count picks the wrong line or leaves a full FIFO still asking for data. A corrupt read or write pointer is caught on the first word read after a block returns, because rdData then shows the wrong lane or a stale value. A missed busy transition shows up as a second engInValid while a block is still in flight, or as a result that never reaches outNotEmpty. The bench drives the engine itself, so both cases can be caught within a few cycles of the handoff.

// File: rtl/cfd_pkg.sv
package cfd_pkg;
  // Per-cycle strobes from control to datapath
  typedef struct packed {
    logic inPush;   // accept one word into input FIFO
    logic inPop;    // remove one block from input FIFO
    logic outPush;  // store one result block
    logic outPop;   // remove one word from output FIFO
    logic flush;    // empty both FIFOs
  } strobe_t;
endpackage

// File: rtl/cfd_datapath.sv
module cfd_datapath
  import cfd_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  parameter int BLK   = 4,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [DW-1:0]     wrData,
  input  logic [BLK*DW-1:0] engOutData,
  output logic [BLK*DW-1:0] engInData,
  output logic [DW-1:0]     rdData,
  output logic [CW-1:0]     inCnt,
  output logic [CW-1:0]     outCnt
);
  logic [DW-1:0] inMem  [DEPTH];
  logic [DW-1:0] outMem [DEPTH];
  logic [AW-1:0] inWr, inRd, outWr, outRd;

  // Storage has no reset
  always_ff @(posedge clk) begin
    if (stb.inPush && !stb.flush) inMem[inWr] <= wrData;
    if (stb.outPush && !stb.flush) begin
      for (int i = 0; i < BLK; i++)
        outMem[outWr + AW'(i)] <= engOutData[i*DW +: DW];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inWr <= '0; inRd <= '0; outWr <= '0; outRd <= '0;
      inCnt <= '0; outCnt <= '0;
    end else if (stb.flush) begin
      inWr <= '0; inRd <= '0; outWr <= '0; outRd <= '0;
      inCnt <= '0; outCnt <= '0;
    end else begin
      if (stb.inPush)  inWr  <= inWr + 1'b1;
      if (stb.inPop)   inRd  <= inRd + AW'(BLK);
      if (stb.outPush) outWr <= outWr + AW'(BLK);
      if (stb.outPop)  outRd <= outRd + 1'b1;
      inCnt  <= inCnt + CW'(stb.inPush) - (stb.inPop ? CW'(BLK) : '0);
      outCnt <= outCnt + (stb.outPush ? CW'(BLK) : '0) - CW'(stb.outPop);
    end
  end

  for (genvar g = 0; g < BLK; g++) begin : gLane
    assign engInData[g*DW +: DW] = inMem[inRd + AW'(g)];
  end

  assign rdData = (outCnt != '0) ? outMem[outRd] : '0;
endmodule

// File: rtl/cfd_ctrl.sv
module cfd_ctrl
  import cfd_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int BLK   = 4,
  parameter int BURST = 4,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          unitEn,
  input  logic          flushReq,
  input  logic          inDmaEn,
  input  logic          outDmaEn,
  input  logic          inIrqEn,
  input  logic          outIrqEn,
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic [CW-1:0] inCnt,
  input  logic [CW-1:0] outCnt,
  input  logic          engInReady,
  input  logic          engOutValid,
  output strobe_t       stb,
  output logic          engInValid,
  output logic          engOutReady,
  output logic          busy,
  output logic          ovfErr,
  output logic          inNotFull,
  output logic          outNotEmpty,
  output logic [1:0]    irqRaw,
  output logic [1:0]    irqMasked,
  output logic          irq,
  output logic          inDmaSingle,
  output logic          inDmaBurst,
  output logic          outDmaSingle,
  output logic          outDmaBurst
);
  logic [CW-1:0] inFree, outFree;
  logic          outReqAny;

  assign inFree      = CW'(DEPTH) - inCnt;
  assign outFree     = CW'(DEPTH) - outCnt;
  assign inNotFull   = (inFree != '0);
  assign outNotEmpty = (outCnt != '0);

  assign engInValid  = unitEn && !busy && (inCnt >= CW'(BLK)) && (outFree >= CW'(BLK));
  assign engOutReady = busy;

  always_comb begin
    stb.flush   = flushReq && !unitEn;
    stb.inPush  = wrEn && inNotFull;
    stb.inPop   = engInValid && engInReady;
    stb.outPush = engOutValid && engOutReady;
    stb.outPop  = rdEn && outNotEmpty;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      ovfErr <= 1'b0;
    end else begin
      if (stb.inPop)        busy <= 1'b1;
      else if (stb.outPush) busy <= 1'b0;
      if (stb.flush)                ovfErr <= 1'b0;
      else if (wrEn && !inNotFull)  ovfErr <= 1'b1;
    end
  end

  // Output requests first; input requests yield to them
  assign outDmaBurst  = outDmaEn && (outCnt >= CW'(BURST));
  assign outDmaSingle = outDmaEn && outNotEmpty && !outDmaBurst;
  assign outReqAny    = outDmaBurst || outDmaSingle;
  assign inDmaBurst   = inDmaEn && !outReqAny && (inFree >= CW'(BURST));
  assign inDmaSingle  = inDmaEn && !outReqAny && inNotFull && !(inFree >= CW'(BURST));

  assign irqRaw    = {outNotEmpty, inNotFull};
  assign irqMasked = irqRaw & {outIrqEn, inIrqEn};
  assign irq       = |irqMasked;
endmodule

// File: rtl/cfd_front.sv
module cfd_front
  import cfd_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  parameter int BLK   = 4,
  parameter int BURST = 4,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              unitEn,
  input  logic              flushReq,
  input  logic              inDmaEn,
  input  logic              outDmaEn,
  input  logic              inIrqEn,
  input  logic              outIrqEn,
  input  logic              wrEn,
  input  logic [DW-1:0]     wrData,
  input  logic              rdEn,
  output logic [DW-1:0]     rdData,
  output logic              inNotFull,
  output logic              outNotEmpty,
  output logic              busy,
  output logic              ovfErr,
  output logic [1:0]        irqRaw,
  output logic [1:0]        irqMasked,
  output logic              irq,
  output logic              inDmaSingle,
  output logic              inDmaBurst,
  output logic              outDmaSingle,
  output logic              outDmaBurst,
  output logic              engInValid,
  input  logic              engInReady,
  output logic [BLK*DW-1:0] engInData,
  input  logic              engOutValid,
  output logic              engOutReady,
  input  logic [BLK*DW-1:0] engOutData
);
  strobe_t       stb;
  logic [CW-1:0] inCnt, outCnt;

  cfd_ctrl #(.DEPTH(DEPTH), .BLK(BLK), .BURST(BURST)) uCtrl (
    .clk(clk), .rstN(rstN), .unitEn(unitEn), .flushReq(flushReq),
    .inDmaEn(inDmaEn), .outDmaEn(outDmaEn), .inIrqEn(inIrqEn), .outIrqEn(outIrqEn),
    .wrEn(wrEn), .rdEn(rdEn), .inCnt(inCnt), .outCnt(outCnt),
    .engInReady(engInReady), .engOutValid(engOutValid), .stb(stb),
    .engInValid(engInValid), .engOutReady(engOutReady), .busy(busy), .ovfErr(ovfErr),
    .inNotFull(inNotFull), .outNotEmpty(outNotEmpty), .irqRaw(irqRaw),
    .irqMasked(irqMasked), .irq(irq), .inDmaSingle(inDmaSingle), .inDmaBurst(inDmaBurst),
    .outDmaSingle(outDmaSingle), .outDmaBurst(outDmaBurst)
  );

  cfd_datapath #(.DW(DW), .DEPTH(DEPTH), .BLK(BLK)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData), .engOutData(engOutData),
    .engInData(engInData), .rdData(rdData), .inCnt(inCnt), .outCnt(outCnt)
  );
endmodule

// File: rtl/cfd_checker.sv
module cfd_checker #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rstN,
  input logic          unitEn,
  input logic          flushReq,
  input logic          wrEn,
  input logic [DW-1:0] rdData,
  input logic          inNotFull,
  input logic          outNotEmpty,
  input logic          busy,
  input logic          ovfErr,
  input logic          inDmaSingle,
  input logic          inDmaBurst,
  input logic          outDmaSingle,
  input logic          outDmaBurst,
  input logic          engInValid,
  input logic          engInReady
);
  assert_ovf_set_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !inNotFull && !(flushReq && !unitEn)) |=> ovfErr);

  assert_empty_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    !outNotEmpty |-> (rdData == '0));

  assert_no_offer_busy_R4: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !engInValid);

  assert_busy_rise_R5: assert property (@(posedge clk) disable iff (!rstN)
    (engInValid && engInReady) |=> busy);

  assert_in_req_onehot_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({inDmaSingle, inDmaBurst}));

  assert_out_req_onehot_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({outDmaSingle, outDmaBurst}));

  assert_out_first_R8: assert property (@(posedge clk) disable iff (!rstN)
    (outDmaSingle || outDmaBurst) |-> !(inDmaSingle || inDmaBurst));

  assert_flush_held_R9: assert property (@(posedge clk) disable iff (!rstN)
    (unitEn && ovfErr) |=> ovfErr);
endmodule

bind cfd_front cfd_checker #(.DW(DW)) uChk (
  .clk(clk), .rstN(rstN), .unitEn(unitEn), .flushReq(flushReq), .wrEn(wrEn),
  .rdData(rdData), .inNotFull(inNotFull), .outNotEmpty(outNotEmpty), .busy(busy),
  .ovfErr(ovfErr), .inDmaSingle(inDmaSingle), .inDmaBurst(inDmaBurst),
  .outDmaSingle(outDmaSingle), .outDmaBurst(outDmaBurst),
  .engInValid(engInValid), .engInReady(engInReady)
);

// File: tb/sim_cfd_front.sv
`timescale 1ns/1ps
module sim_cfd_front;
  localparam int DW = 32, BLK = 4, LAT = 3;
  localparam logic [DW-1:0] KEY = 32'h5A5A_F00F;

  logic clk = 1'b0, rstN = 1'b0;
  logic unitEn = 0, flushReq = 0, inDmaEn = 0, outDmaEn = 0, inIrqEn = 0, outIrqEn = 0;
  logic wrEn = 0, rdEn = 0;
  logic [DW-1:0] wrData = '0, rdData;
  logic inNotFull, outNotEmpty, busy, ovfErr, irq;
  logic [1:0] irqRaw, irqMasked;
  logic inDmaSingle, inDmaBurst, outDmaSingle, outDmaBurst;
  logic engInValid, engOutReady;
  logic engInReady = 1'b1;
  logic engOutValid;
  logic [BLK*DW-1:0] engInData, engOutData, held;
  int lat;
  int nChk = 0, nFail = 0;

  always #2.5 clk = ~clk;

  cfd_front u0 (.*);

  // Engine model: fixed latency, per-word XOR with KEY
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      engOutValid <= 1'b0; engOutData <= '0; held <= '0; lat <= 0;
    end else begin
      if (engInValid && engInReady) begin
        held <= engInData; lat <= LAT;
      end else if (lat != 0) begin
        lat <= lat - 1;
        if (lat == 1) begin
          engOutValid <= 1'b1;
          for (int i = 0; i < BLK; i++) engOutData[i*DW +: DW] <= held[i*DW +: DW] ^ KEY;
        end
      end
      if (engOutValid && engOutReady) engOutValid <= 1'b0;
    end
  end

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wrWord(logic [DW-1:0] d);
    @(negedge clk); wrEn = 1; wrData = d;
    @(negedge clk); wrEn = 0; #1;
  endtask

  task automatic rdWord(string req, logic [DW-1:0] exp);
    @(negedge clk); #1;
    chk(req, rdData, exp);
    rdEn = 1;
    @(negedge clk); rdEn = 0; #1;
  endtask

  task automatic flushPulse();
    @(negedge clk); flushReq = 1;
    @(negedge clk); flushReq = 0; #1;
  endtask

  task automatic t_reset();
    chk("R1 inNotFull", inNotFull, 1);
    chk("R1 outNotEmpty", outNotEmpty, 0);
    chk("R1 busy", busy, 0);
    chk("R1 ovfErr", ovfErr, 0);
    chk("R1 rdData", rdData, 0);
    chk("R1 engInValid", engInValid, 0);
  endtask

  task automatic t_fill();
    inDmaEn = 1; inIrqEn = 1; #1;
    chk("R6 burst when empty", {inDmaBurst, inDmaSingle}, 2'b10);
    chk("R10 irq in", {irqRaw, irqMasked, irq}, 5'b01_01_1);
    for (int i = 0; i < 5; i++) wrWord(32'h100 + i);
    chk("R6 single at 3 free", {inDmaBurst, inDmaSingle}, 2'b01);
    for (int i = 5; i < 8; i++) wrWord(32'h100 + i);
    chk("R2 full flag", inNotFull, 0);
    chk("R6 no req when full", {inDmaBurst, inDmaSingle}, 2'b00);
    chk("R10 irq off when full", {irqRaw, irq}, 3'b00_0);
    chk("R2 no error yet", ovfErr, 0);
    wrWord(32'hDEAD);
    chk("R2 sticky error", ovfErr, 1);
    chk("R2 still full", inNotFull, 0);
    flushPulse();
    chk("R9 flush empties", {inNotFull, inDmaBurst}, 2'b11);
    chk("R9 flush clears error", ovfErr, 0);
  endtask

  task automatic t_block();
    logic [DW-1:0] w [4];
    outDmaEn = 1; outIrqEn = 1;
    for (int i = 0; i < 4; i++) begin w[i] = 32'hA000_0000 + 32'(i * 17 + 3); wrWord(w[i]); end
    chk("R4 no offer while disabled", engInValid, 0);
    @(negedge clk); unitEn = 1; #1;
    chk("R4 offer when enabled", engInValid, 1);
    chk("R4 lane order", engInData, {w[3], w[2], w[1], w[0]});
    @(negedge clk); #1;
    chk("R5 busy after handoff", {busy, engOutReady, engInValid}, 3'b110);
    repeat (LAT + 3) @(negedge clk); #1;
    chk("R5 busy cleared", busy, 0);
    chk("R7 out burst", {outDmaBurst, outDmaSingle}, 2'b10);
    chk("R8 input held back", {inDmaBurst, inDmaSingle}, 2'b00);
    chk("R10 both raw", {irqRaw, irqMasked, irq}, 5'b11_11_1);
    rdWord("R5 first lane out", w[0] ^ KEY);
    chk("R7 out single at 3", {outDmaBurst, outDmaSingle}, 2'b01);
    rdWord("R3 second", w[1] ^ KEY);
    rdWord("R3 third", w[2] ^ KEY);
    rdWord("R3 fourth", w[3] ^ KEY);
    chk("R3 empty flag", {outNotEmpty, rdData}, 33'h0);
    chk("R8 input resumes", {inDmaBurst, inDmaSingle}, 2'b10);
    rdWord("R3 empty read zero", 32'h0);
    rdWord("R3 empty read again", 32'h0);
  endtask

  task automatic t_flushIgnored();
    logic [DW-1:0] w [4];
    outDmaEn = 0;
    for (int i = 0; i < 3; i++) begin w[i] = 32'h0C00 + 32'(i); wrWord(w[i]); end
    chk("R4 no offer below block", engInValid, 0);
    flushPulse();
    w[3] = 32'h0CFF; wrWord(w[3]);
    chk("R9 flush ignored when enabled", engInValid, 1);
    chk("R9 data kept", engInData[DW-1:0], w[0]);
    repeat (LAT + 4) @(negedge clk); #1;
    rdWord("R3 after empty reads", w[0] ^ KEY);
    rdWord("R5 lane1", w[1] ^ KEY);
    rdWord("R5 lane2", w[2] ^ KEY);
    rdWord("R5 lane3", w[3] ^ KEY);
    unitEn = 0;
    for (int i = 0; i < 3; i++) wrWord(32'h77 + i);
    flushPulse();
    wrWord(32'h99);
    @(negedge clk); unitEn = 1; #1;
    chk("R9 flush accepted when disabled", engInValid, 0);
    chk("R9 one word left", {inDmaBurst, inDmaSingle}, 2'b10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1; #1;
    t_reset();
    t_fill();
    t_block();
    t_flushIgnored();
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end
endmodule